// File: doc/BRIEF.md
# Operand Address Generator

This unit turns an addressing mode and the bytes that follow an opcode into the effective operand address for an 8-bit processor core. It runs once per instruction. A one-cycle start pulse gives it the mode code, the address of the first operand byte and the two index registers, and it latches all of them. The unit then reads the operand bytes through a read port. For the pointer modes it also reads a two-byte pointer from page zero. When it has finished, it pulses `done` and presents the effective address, the first operand byte, the advanced program counter and two cycle-accounting flags.

The `page_cross` flag reports that an indexed address left the page of its base address. The `alt_count` flag tells the cycle counter to use the alternate count for the opcode. Read forms of the indexed modes raise `alt_count` only when a page is crossed. Write forms (used by stores) raise it on every instruction. The immediate and relative modes deliver the fetched byte as data and do not report any memory access for it. The no-operand codes, including the unused code 15, still finish so that the core can proceed. The opcode-to-mode decode, execution and the cycle table itself live outside this unit.

The read port has a fixed latency of one cycle. `rd_data` must hold the byte for the address that was requested in the previous cycle.

Top module: `opaddr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `rd_en` are all low.
- R2: Mode codes 0 (none), 1 (implied) and 15 (unused) consume no bytes and make no read. `done` rises in the cycle after start, with `pc_next` equal to the start address and `eff_addr`, `opnd` and `uses_mem` all zero.
- R3: Mode codes 2 (immediate) and 3 (relative) read one byte at the start address and return it on `opnd`. In these modes `uses_mem` is 0, `eff_addr` is 0 and `pc_next` is the start address plus 1. `done` comes 3 cycles after start.
- R4: Mode codes 4, 5 and 6 (page zero, page zero plus X, page zero plus Y) read one byte B and produce `eff_addr` = {8'h00, (B + index) mod 256}, where the index is 0, X or Y. In these modes `uses_mem` is 1, `pc_next` is the start address plus 1, and `done` comes 3 cycles after start.
- R5: Mode codes 10 to 14 (absolute, absolute plus X, its write form, absolute plus Y, its write form) read the low byte at PC and then the high byte at PC+1, both 16-bit wrapping. They produce `eff_addr` = {high, low} + index with the index zero-extended, and `pc_next` = PC+2. `done` comes 4 cycles after start.
- R6: Mode code 7 (indexed pointer) forms P = (B + X) mod 256 and reads page-zero addresses P and (P+1) mod 256; `eff_addr` = {high, low}. Mode codes 8 and 9 (pointer then Y, and its write form) take P = B and produce `eff_addr` = {high, low} + Y. In all three modes `pc_next` is PC+1, `uses_mem` is 1, and `done` comes 5 cycles after start.
- R7: `page_cross` is 1 only for mode codes 8, 9, 11, 12, 13 and 14, and only when the high byte of the effective address differs from the high byte of the base address. It is 0 for every other mode.
- R8: For the read forms, `alt_count` equals `page_cross`. For the write forms (mode codes 9, 12 and 14), `alt_count` is 1 whether or not a page was crossed.
- R9: A start pulse while `busy` is high has no effect. The running instruction keeps its inputs and produces exactly one `done`.
- R10: Every mode code 0 to 15 finishes and pulses `done` for exactly one cycle, with outputs that follow R2 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation (ignored while busy) |
| mode | input | 4 | Addressing mode code, sampled at start |
| pc_in | input | 16 | Address of the first operand byte, sampled at start |
| idx_x | input | 8 | X index register, sampled at start |
| idx_y | input | 8 | Y index register, sampled at start |
| busy | output | 1 | An instruction is in progress |
| rd_en | output | 1 | Read request |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle result strobe |
| eff_addr | output | 16 | Effective operand address |
| opnd | output | 8 | First operand byte (the data itself in immediate mode) |
| uses_mem | output | 1 | The operand lives in memory at `eff_addr` |
| page_cross | output | 1 | Indexed address left its base page |
| alt_count | output | 1 | Use the alternate per-opcode cycle count |
| pc_next | output | 16 | Program counter after the operand bytes |

## Verification
The assertions assume that `rd_data` always answers the request made one cycle earlier. They also assume that the mode, program counter and index inputs need to be valid only on the start cycle. The bench keeps within these assumptions by modelling memory as a register that loads only on `rd_en`. It also drives deliberately wrong values on the mode and address inputs after each start pulse, so a design that failed to latch them would produce wrong results. Page-zero wrap, program-counter wrap at the top of memory, pointer wrap at address 0xFF and crossings with and without the write forms are all stimulated explicitly. A final sweep then covers all sixteen mode codes with varied index values.

// File: rtl/opgen_pkg.sv
package opgen_pkg;

   typedef enum logic [3:0] {
      AM_NONE  = 4'd0,
      AM_IMPL  = 4'd1,
      AM_IMM   = 4'd2,
      AM_REL   = 4'd3,
      AM_ZP    = 4'd4,
      AM_ZPX   = 4'd5,
      AM_ZPY   = 4'd6,
      AM_INDX  = 4'd7,
      AM_INDY  = 4'd8,
      AM_INDYW = 4'd9,
      AM_ABS   = 4'd10,
      AM_ABSX  = 4'd11,
      AM_ABSXW = 4'd12,
      AM_ABSY  = 4'd13,
      AM_ABSYW = 4'd14,
      AM_UNDEF = 4'd15
   } amode_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_OP0, ST_OP1, ST_OP2, ST_PLO, ST_PHI
   } seq_e;

   // number of operand bytes taken from the instruction stream
   function automatic logic [1:0] am_len(amode_e m);
      case (m)
         AM_NONE, AM_IMPL, AM_UNDEF:                  am_len = 2'd0;
         AM_ABS, AM_ABSX, AM_ABSXW, AM_ABSY, AM_ABSYW: am_len = 2'd2;
         default:                                     am_len = 2'd1;
      endcase
   endfunction

   function automatic logic am_wvar(amode_e m);
      am_wvar = (m == AM_INDYW) || (m == AM_ABSXW) || (m == AM_ABSYW);
   endfunction

   function automatic logic am_zp(amode_e m);
      am_zp = (m == AM_ZP) || (m == AM_ZPX) || (m == AM_ZPY);
   endfunction

   function automatic logic am_ptr(amode_e m);
      am_ptr = (m == AM_INDX) || (m == AM_INDY) || (m == AM_INDYW);
   endfunction

   function automatic logic am_xidx(amode_e m);
      am_xidx = (m == AM_ABSX) || (m == AM_ABSXW);
   endfunction

   function automatic logic am_yidx(amode_e m);
      am_yidx = (m == AM_ABSY) || (m == AM_ABSYW) || (m == AM_INDY) || (m == AM_INDYW);
   endfunction

endpackage

// File: rtl/opgen_page_add.sv
// Adds a small increment to an address, either staying inside the page
// of the base (WRAP=1) or carrying into the high part (WRAP=0).
module opgen_page_add #(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter bit WRAP = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] inc,
   output logic [AW-1:0] sum
);
   localparam int HW = AW - DW;

   generate
      if (WRAP) begin : g_wrap
         logic [DW-1:0] low;
         assign low = base[DW-1:0] + inc;
         assign sum = {base[AW-1:DW], low};
      end else begin : g_carry
         assign sum = base + {{HW{1'b0}}, inc};
      end
   endgenerate
endmodule

// File: rtl/opgen_index_add.sv
// Full-width base plus index, with page-change detection.
module opgen_index_add #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] idx,
   output logic [AW-1:0] sum,
   output logic          crossed
);
   localparam int HW = AW - DW;

   assign sum     = base + {{HW{1'b0}}, idx};
   assign crossed = (sum[AW-1:DW] != base[AW-1:DW]);
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
   import opgen_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 8,
   parameter bit ZP_WRAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [AW-1:0] pc_in,
   input  logic [DW-1:0] idx_x,
   input  logic [DW-1:0] idx_y,
   output logic          busy,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic          done,
   output logic [AW-1:0] eff_addr,
   output logic [DW-1:0] opnd,
   output logic          uses_mem,
   output logic          page_cross,
   output logic          alt_count,
   output logic [AW-1:0] pc_next
);
   localparam int HW = AW - DW;
   localparam logic [AW-1:0] PC_ONE = AW'(1);
   localparam logic [AW-1:0] PC_TWO = AW'(2);
   localparam logic [DW-1:0] D_ONE  = DW'(1);

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("opaddr_gen: AW must be twice DW");
      end
      if (DW < 2) begin : g_bad_dw
         $error("opaddr_gen: DW too small");
      end
   endgenerate

   seq_e          st_q, st_d;
   amode_e        mode_q;
   amode_e        mode_in;
   logic [AW-1:0] pc_q, ptr_q;
   logic [DW-1:0] x_q, y_q, b0_q, lo_q;

   logic [DW-1:0] zp_inc, ix_inc;
   logic [AW-1:0] zp_sum, ptr_nxt, ix_sum, pc_inc1, pc_inc2;
   logic          ix_cross;

   logic          fin, f_mem, f_cross, f_alt, lo_ld, ptr_ld;
   logic [AW-1:0] f_eff, f_pc;
   logic [DW-1:0] f_opnd;

   assign mode_in = amode_e'(mode);
   assign busy    = (st_q != ST_IDLE);
   assign pc_inc1 = pc_q + PC_ONE;
   assign pc_inc2 = pc_q + PC_TWO;

   // page-zero index / pointer base
   always_comb begin
      if (mode_q == AM_ZPY)                          zp_inc = y_q;
      else if (mode_q == AM_ZPX || mode_q == AM_INDX) zp_inc = x_q;
      else                                           zp_inc = '0;
   end

   always_comb begin
      if (am_xidx(mode_q))      ix_inc = x_q;
      else if (am_yidx(mode_q)) ix_inc = y_q;
      else                      ix_inc = '0;
   end

   opgen_page_add #(.AW(AW), .DW(DW), .WRAP(ZP_WRAP)) u_zp_add (
      .base ({{HW{1'b0}}, rd_data}),
      .inc  (zp_inc),
      .sum  (zp_sum)
   );

   opgen_page_add #(.AW(AW), .DW(DW), .WRAP(ZP_WRAP)) u_ptr_add (
      .base (ptr_q),
      .inc  (D_ONE),
      .sum  (ptr_nxt)
   );

   opgen_index_add #(.AW(AW), .DW(DW)) u_ix_add (
      .base    ({rd_data, lo_q}),
      .idx     (ix_inc),
      .sum     (ix_sum),
      .crossed (ix_cross)
   );

   // sequencer: each state consumes the byte requested by the previous one
   always_comb begin
      st_d    = st_q;
      rd_en   = 1'b0;
      rd_addr = '0;
      fin     = 1'b0;
      f_eff   = '0;
      f_opnd  = '0;
      f_mem   = 1'b0;
      f_cross = 1'b0;
      f_alt   = 1'b0;
      f_pc    = pc_q;
      lo_ld   = 1'b0;
      ptr_ld  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               if (am_len(mode_in) == 2'd0) begin
                  fin  = 1'b1;
                  f_pc = pc_in;
               end else begin
                  st_d = ST_OP0;
               end
            end
         end
         ST_OP0: begin
            rd_en   = 1'b1;
            rd_addr = pc_q;
            st_d    = ST_OP1;
         end
         ST_OP1: begin
            if (am_len(mode_q) == 2'd2) begin
               rd_en   = 1'b1;
               rd_addr = pc_inc1;
               lo_ld   = 1'b1;
               st_d    = ST_OP2;
            end else if (am_ptr(mode_q)) begin
               rd_en   = 1'b1;
               rd_addr = zp_sum;
               ptr_ld  = 1'b1;
               st_d    = ST_PLO;
            end else begin
               fin    = 1'b1;
               f_opnd = rd_data;
               f_pc   = pc_inc1;
               f_mem  = am_zp(mode_q);
               f_eff  = am_zp(mode_q) ? zp_sum : '0;
            end
         end
         ST_OP2: begin
            fin     = 1'b1;
            f_opnd  = b0_q;
            f_pc    = pc_inc2;
            f_mem   = 1'b1;
            f_eff   = ix_sum;
            f_cross = ix_cross;
            f_alt   = ix_cross | am_wvar(mode_q);
         end
         ST_PLO: begin
            rd_en   = 1'b1;
            rd_addr = ptr_nxt;
            lo_ld   = 1'b1;
            st_d    = ST_PHI;
         end
         ST_PHI: begin
            fin     = 1'b1;
            f_opnd  = b0_q;
            f_pc    = pc_inc1;
            f_mem   = 1'b1;
            f_eff   = ix_sum;
            f_cross = ix_cross;
            f_alt   = ix_cross | am_wvar(mode_q);
         end
         default: st_d = ST_IDLE;
      endcase
      if (fin) st_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= AM_NONE;
         pc_q   <= '0;
         x_q    <= '0;
         y_q    <= '0;
         b0_q   <= '0;
         lo_q   <= '0;
         ptr_q  <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start) begin
            mode_q <= mode_in;
            pc_q   <= pc_in;
            x_q    <= idx_x;
            y_q    <= idx_y;
         end
         if (st_q == ST_OP1) b0_q <= rd_data;
         if (lo_ld)          lo_q <= rd_data;
         if (ptr_ld)         ptr_q <= zp_sum;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         eff_addr   <= '0;
         opnd       <= '0;
         uses_mem   <= 1'b0;
         page_cross <= 1'b0;
         alt_count  <= 1'b0;
         pc_next    <= '0;
      end else begin
         done <= fin;
         if (fin) begin
            eff_addr   <= f_eff;
            opnd       <= f_opnd;
            uses_mem   <= f_mem;
            page_cross <= f_cross;
            alt_count  <= f_alt;
            pc_next    <= f_pc;
         end
      end
   end

   // no read request outside an instruction (R1)
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_en);

   // no-operand codes leave no memory reference (R2)
   a_r2_no_operand: assert property (@(posedge clk) disable iff (!rst_n)
      done && (am_len(mode_q) == 2'd0) |-> !uses_mem && (eff_addr == '0));

   // immediate data is never a memory reference (R3)
   a_r3_imm_direct: assert property (@(posedge clk) disable iff (!rst_n)
      done && (mode_q == AM_IMM) |-> !uses_mem);

   // page-zero results stay in page zero (R4)
   a_r4_zp_page: assert property (@(posedge clk) disable iff (!rst_n)
      ZP_WRAP && done && am_zp(mode_q) |-> (eff_addr[AW-1:DW] == '0));

   // program counter advances by the operand length (R10)
   a_r10_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pc_next == pc_q + AW'(am_len(mode_q))));

   // crossing only reported for indexed modes (R7)
   a_r7_cross_scope: assert property (@(posedge clk) disable iff (!rst_n)
      done && !am_xidx(mode_q) && !am_yidx(mode_q) |-> !page_cross);

   // write forms always take the alternate count (R8)
   a_r8_write_alt: assert property (@(posedge clk) disable iff (!rst_n)
      done && am_wvar(mode_q) |-> alt_count);

   // start during an instruction leaves its latched inputs alone (R9)
   a_r9_start_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(mode_q) && $stable(pc_q));

endmodule

// File: tb/tb_opaddr_gen.sv
`timescale 1ns/1ps
module tb_opaddr_gen;
   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    mode = 4'd0;
   logic [AW-1:0] pc_in = '0;
   logic [DW-1:0] idx_x = '0, idx_y = '0;
   logic          busy, rd_en, done, uses_mem, page_cross, alt_count;
   logic [AW-1:0] rd_addr, eff_addr, pc_next;
   logic [DW-1:0] rd_data = '0, opnd;

   always #4 clk = ~clk;

   opaddr_gen #(.AW(AW), .DW(DW), .ZP_WRAP(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
      .idx_x(idx_x), .idx_y(idx_y), .busy(busy), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .eff_addr(eff_addr),
      .opnd(opnd), .uses_mem(uses_mem), .page_cross(page_cross),
      .alt_count(alt_count), .pc_next(pc_next)
   );

   logic [7:0]  mem [0:65535];
   logic [15:0] rdlog [$];
   int          cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rd_en) begin
         rd_data <= mem[rd_addr];
         rdlog.push_back(rd_addr);
      end
   end

   typedef struct {
      logic [15:0] eff;
      logic [7:0]  opnd;
      logic        um;
      logic        pcross;
      logic        alt;
      logic [15:0] pcn;
      int          lat;
      int          nrd;
      logic [15:0] rd0, rd1, rd2;
      int          scyc;
      string       tag;
   } exp_t;

   exp_t sbq [$];
   int   checks = 0, fails = 0, extra_done = 0;
   bit   finished = 1'b0;

   task automatic predict(input logic [3:0] m, input logic [15:0] pc,
                          input logic [7:0] x, input logic [7:0] y,
                          input string tag, output exp_t e);
      logic [7:0]  b, lo, hi, p, p1, zi, ix;
      logic [15:0] base, pc1;
      e.tag = tag; e.eff = 16'h0; e.opnd = 8'h0; e.um = 1'b0; e.pcross = 1'b0;
      e.alt = 1'b0; e.pcn = pc; e.lat = 1; e.nrd = 0;
      e.rd0 = 16'h0; e.rd1 = 16'h0; e.rd2 = 16'h0; e.scyc = 0;
      pc1 = pc + 16'd1;
      b   = mem[pc];
      case (m)
         4'd0, 4'd1, 4'd15: begin end
         4'd2, 4'd3: begin
            e.opnd = b; e.pcn = pc1; e.lat = 3; e.nrd = 1; e.rd0 = pc;
         end
         4'd4, 4'd5, 4'd6: begin
            zi = (m == 4'd5) ? x : (m == 4'd6) ? y : 8'h00;
            p = b + zi;
            e.opnd = b; e.eff = {8'h00, p}; e.um = 1'b1; e.pcn = pc1;
            e.lat = 3; e.nrd = 1; e.rd0 = pc;
         end
         4'd7, 4'd8, 4'd9: begin
            p  = (m == 4'd7) ? (b + x) : b;
            p1 = p + 8'd1;
            lo = mem[{8'h00, p}];
            hi = mem[{8'h00, p1}];
            base = {hi, lo};
            ix = (m == 4'd7) ? 8'h00 : y;
            e.eff = base + {8'h00, ix};
            e.pcross = (e.eff[15:8] != base[15:8]);
            e.alt = (m == 4'd9) ? 1'b1 : e.pcross;
            e.opnd = b; e.um = 1'b1; e.pcn = pc1; e.lat = 5; e.nrd = 3;
            e.rd0 = pc; e.rd1 = {8'h00, p}; e.rd2 = {8'h00, p1};
         end
         default: begin
            lo = b;
            hi = mem[pc1];
            base = {hi, lo};
            ix = (m == 4'd11 || m == 4'd12) ? x : (m == 4'd13 || m == 4'd14) ? y : 8'h00;
            e.eff = base + {8'h00, ix};
            e.pcross = (e.eff[15:8] != base[15:8]);
            e.alt = (m == 4'd12 || m == 4'd14) ? 1'b1 : e.pcross;
            e.opnd = b; e.um = 1'b1; e.pcn = pc + 16'd2; e.lat = 4; e.nrd = 2;
            e.rd0 = pc; e.rd1 = pc1;
         end
      endcase
   endtask

   // monitor: compare each result strobe against the head of the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            if (sbq.size() == 0) begin
               extra_done++;
            end else begin
               exp_t e;
               int   lat;
               bit   rok;
               e   = sbq.pop_front();
               lat = cyc - e.scyc;
               checks++;
               if (eff_addr !== e.eff || opnd !== e.opnd || uses_mem !== e.um ||
                   page_cross !== e.pcross || alt_count !== e.alt || pc_next !== e.pcn) begin
                  fails++;
                  $display("FAIL %s fields: got eff=%h opnd=%h mem=%b cross=%b alt=%b pc=%h exp eff=%h opnd=%h mem=%b cross=%b alt=%b pc=%h",
                           e.tag, eff_addr, opnd, uses_mem, page_cross, alt_count, pc_next,
                           e.eff, e.opnd, e.um, e.pcross, e.alt, e.pcn);
               end
               checks++;
               if (lat != e.lat) begin
                  fails++;
                  $display("FAIL %s latency: got %0d exp %0d", e.tag, lat, e.lat);
               end
               checks++;
               rok = (rdlog.size() == e.nrd);
               if (rok && e.nrd > 0) rok = (rdlog[0] == e.rd0);
               if (rok && e.nrd > 1) rok = (rdlog[1] == e.rd1);
               if (rok && e.nrd > 2) rok = (rdlog[2] == e.rd2);
               if (!rok) begin
                  fails++;
                  $display("FAIL %s reads: got count %0d first %h exp count %0d seq %h %h %h",
                           e.tag, rdlog.size(), (rdlog.size() > 0) ? rdlog[0] : 16'h0,
                           e.nrd, e.rd0, e.rd1, e.rd2);
               end
            end
            rdlog.delete();
         end
      end
   end

   task automatic issue(input logic [3:0] m, input logic [15:0] pc,
                        input logic [7:0] x, input logic [7:0] y, input string tag);
      exp_t e;
      predict(m, pc, x, y, tag, e);
      @(negedge clk);
      e.scyc = cyc;
      sbq.push_back(e);
      start = 1'b1; mode = m; pc_in = pc; idx_x = x; idx_y = y;
      @(negedge clk);
      start = 1'b0; mode = ~m; pc_in = ~pc; idx_x = ~x; idx_y = ~y;
      while (sbq.size() != 0) @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R10 watchdog: got no completion after %0d cycles exp completion", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 37 + (i >> 8) * 11);

      repeat (3) @(negedge clk);
      checks++;
      if (busy !== 1'b0 || done !== 1'b0 || rd_en !== 1'b0) begin
         fails++;
         $display("FAIL R1 in reset: got busy=%b done=%b rd=%b exp 0 0 0", busy, done, rd_en);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (busy !== 1'b0 || done !== 1'b0 || rd_en !== 1'b0) begin
         fails++;
         $display("FAIL R1 after reset: got busy=%b done=%b rd=%b exp 0 0 0", busy, done, rd_en);
      end

      issue(4'd1, 16'h1234, 8'h11, 8'h22, "R2 implied");
      issue(4'd0, 16'h2000, 8'h00, 8'h00, "R2 none");
      issue(4'd15, 16'h2100, 8'h05, 8'h06, "R2 unused code");

      mem[16'h1234] = 8'hA7;
      issue(4'd2, 16'h1234, 8'h00, 8'h00, "R3 immediate");
      mem[16'h1300] = 8'h80;
      issue(4'd3, 16'h1300, 8'h00, 8'h00, "R3 relative");

      mem[16'h0400] = 8'h3C;
      issue(4'd4, 16'h0400, 8'h55, 8'h66, "R4 page zero");
      mem[16'h0410] = 8'hF0;
      issue(4'd5, 16'h0410, 8'h20, 8'h00, "R4 page zero plus X wraps");
      mem[16'h0420] = 8'h7F;
      issue(4'd6, 16'h0420, 8'h00, 8'h81, "R4 page zero plus Y wraps");

      mem[16'h0500] = 8'h34; mem[16'h0501] = 8'h12;
      issue(4'd10, 16'h0500, 8'h40, 8'h40, "R5 absolute");
      mem[16'h0510] = 8'h10; mem[16'h0511] = 8'h22;
      issue(4'd11, 16'h0510, 8'h05, 8'h00, "R5 R7 absolute X no crossing");
      mem[16'h0520] = 8'hF0; mem[16'h0521] = 8'h22;
      issue(4'd11, 16'h0520, 8'h20, 8'h00, "R7 absolute X crossing");
      issue(4'd12, 16'h0510, 8'h05, 8'h00, "R8 absolute X write no crossing");
      issue(4'd13, 16'h0520, 8'h00, 8'hFF, "R7 absolute Y crossing");
      issue(4'd14, 16'h0520, 8'h00, 8'h10, "R8 absolute Y write crossing");
      mem[16'hFFFF] = 8'h78; mem[16'h0000] = 8'h56;
      issue(4'd10, 16'hFFFF, 8'h00, 8'h00, "R5 counter wraps at top");

      mem[16'h0600] = 8'hFE; mem[16'h00FF] = 8'hCD; mem[16'h0000] = 8'hAB;
      issue(4'd7, 16'h0600, 8'h01, 8'h00, "R6 indexed pointer wraps");
      mem[16'h0610] = 8'h40; mem[16'h0040] = 8'hF8; mem[16'h0041] = 8'h30;
      issue(4'd8, 16'h0610, 8'h00, 8'h10, "R6 R7 pointer then Y crossing");
      mem[16'h0620] = 8'h50; mem[16'h0050] = 8'h00; mem[16'h0051] = 8'h40;
      issue(4'd9, 16'h0620, 8'h00, 8'h05, "R8 pointer then Y write no crossing");
      mem[16'h0630] = 8'hFF; mem[16'h00FF] = 8'h11; mem[16'h0000] = 8'h22;
      issue(4'd8, 16'h0630, 8'h00, 8'h00, "R6 pointer at FF wraps");

      for (int k = 0; k < 48; k++) begin
         issue(4'(k % 16), 16'(k * 16'h0123 + 16'h0700), 8'(k * 29), 8'(k * 53 + 7),
               "R10 sweep");
      end

      // R9: a second start while busy must be ignored
      begin
         exp_t e;
         mem[16'h0800] = 8'h9A; mem[16'h0801] = 8'h44;
         predict(4'd10, 16'h0800, 8'h00, 8'h00, "R9 start while busy", e);
         @(negedge clk);
         e.scyc = cyc;
         sbq.push_back(e);
         start = 1'b1; mode = 4'd10; pc_in = 16'h0800;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         start = 1'b1; mode = 4'd1; pc_in = 16'h0900;
         @(negedge clk);
         start = 1'b0;
         while (sbq.size() != 0) @(negedge clk);
         repeat (12) @(negedge clk);
         checks++;
         if (extra_done != 0) begin
            fails++;
            $display("FAIL R9 extra result strobes: got %0d exp 0", extra_done);
         end
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule